// File: doc/BRIEF.md
# Monitoring rule table

This block is the decision table of a per-word memory monitor. Every data word in a monitored program carries a small state code, and each memory event that touches the word is classified by type. The classes are full-word load, full-word store, sub-word load, sub-word store and a set of user events that software issues to mark allocation, release or similar actions. The table takes the word's current state and the event code. One clock later it returns the state the word moves to and whether a software handler must be raised. Software fills the table and a per-event mask through a simple write port. A different table image turns the same hardware into a different checker.

A masked event, or an event code beyond the configured count, skips the table entirely. The result is then flagged as a bypass, with the state unchanged and no exception. This lets instrumentation for a disabled checker stay in the code at no state cost. The caller reads and writes the state memory itself. Acting on a raised exception is also the caller's job.

Top module: `mon_rule_table`

## Requirements
- R1: After reset every table entry maps a state to itself with the exception bit clear, every mask bit is clear, and all result outputs are 0.
- R2: A lookup presented with `lk_valid` high yields its result with `rs_valid` high in the next cycle, and back-to-back lookups give one result per cycle. In a cycle after which no lookup was presented, `rs_valid`, `rs_next`, `rs_exc`, `rs_changed` and `rs_bypass` are all 0.
- R3: The entry for event e and state s sits at index {e[5:0], s[3:0]}. A write with `tbl_we` high stores `tbl_next` and `tbl_exc` there, and later lookups of (s, e) return them. Event codes: 0 full-word load, 1 full-word store, 2 sub-word load, 3 sub-word store, 4 to 35 user events 0 to 31.
- R4: Sub-word load and store (codes 2 and 3) have entries of their own. Programming a full-word event's entry leaves the sub-word entries for the same state unchanged, and the reverse holds as well.
- R5: While mask bit e (bit e of `mask_wdata` as last written with `mask_we`) is 1, a lookup of event e gives `rs_bypass`=1, `rs_next` equal to the presented state, and `rs_exc`=`rs_changed`=0. This holds for loads, stores and user events alike. Clearing the bit restores table results.
- R6: A lookup with an event code of 36 or above is treated as masked (bypass, state kept, no exception). A table write to such an index has no effect.
- R7: `rs_changed` is 1 exactly when the result is not a bypass, `rs_exc` is 0, and `rs_next` differs from the presented state.
- R8: When the addressed entry has its exception bit set, the result gives `rs_exc`=1, `rs_next` equal to the entry's stored next state, and `rs_changed`=0.
- R9: A table write and a lookup of the same entry in the same cycle return the entry's old contents. A mask write and a lookup in the same cycle use the old mask.
- R10: An entry programmed with next state equal to its own state and no exception yields `rs_next` equal to the presented state, with `rs_exc`=`rs_changed`=`rs_bypass`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 10 | Entry index {event, state} |
| tbl_next | input | 4 | Next-state field written |
| tbl_exc | input | 1 | Exception bit written |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 36 | New mask, bit per event code, 1 = skip |
| lk_valid | input | 1 | Lookup request |
| lk_state | input | 4 | Current state of the word |
| lk_event | input | 6 | Event code |
| rs_valid | output | 1 | Result valid, one cycle after request |
| rs_next | output | 4 | State the word moves to |
| rs_exc | output | 1 | Raise the software handler |
| rs_changed | output | 1 | State moves with no exception |
| rs_bypass | output | 1 | Table was skipped (masked or unknown event) |

## Verification
The bench builds the block with its default parameters: 4 state bits and 36 event codes. With these values the 6-bit event field has 28 unused codes (36 to 63) that must bypass, and the highest real code, 35, sits next to the first unused one. Sixteen states make a full sweep of one event row short. That sweep reaches both halves of the index concatenation, and it covers the neighbouring full-word and sub-word rows of one state.

// File: rtl/mon_rule_pkg.sv
package mon_rule_pkg;
   // Event code assignment shared by the table and its users
   localparam int EV_LOAD      = 0;
   localparam int EV_STORE     = 1;
   localparam int EV_SUB_LOAD  = 2;
   localparam int EV_SUB_STORE = 3;
   localparam int EV_USER0     = 4;
   localparam int EV_FIXED     = 4;   // non-user event kinds
endpackage

// File: rtl/mon_rule_store.sv
module mon_rule_store #(
   parameter int STATE_W    = 4,
   parameter int NUM_EVENTS = 36
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       we,
   input  logic [$clog2(NUM_EVENTS)+STATE_W-1:0]      widx,
   input  logic [STATE_W-1:0]                         wnext,
   input  logic                                       wexc,
   input  logic [$clog2(NUM_EVENTS)-1:0]              rev,
   input  logic [STATE_W-1:0]                         rst_sel,
   output logic [STATE_W-1:0]                         rnext,
   output logic                                       rexc
);
   localparam int EVT_W      = $clog2(NUM_EVENTS);
   localparam int IDX_W      = EVT_W + STATE_W;
   localparam int NUM_STATES = 1 << STATE_W;
   localparam int ENT_W      = STATE_W + 1;
   localparam int ROW_W      = NUM_STATES * ENT_W;

   function automatic logic [ROW_W-1:0] identity_row();
      logic [ROW_W-1:0] r;
      r = '0;
      for (int s = 0; s < NUM_STATES; s++)
         r[s*ENT_W +: ENT_W] = {1'b0, STATE_W'(s)};
      return r;
   endfunction

   logic [EVT_W-1:0]   w_ev;
   logic [STATE_W-1:0] w_st;
   logic [ROW_W-1:0]   rows [NUM_EVENTS];
   logic               rd_ok;
   logic [ROW_W-1:0]   rd_row;
   logic [ENT_W-1:0]   rd_ent;

   assign w_ev = widx[IDX_W-1:STATE_W];
   assign w_st = widx[STATE_W-1:0];

   // one register row per event code, each reset to the identity mapping
   for (genvar ev = 0; ev < NUM_EVENTS; ev++) begin : g_row
      logic [ROW_W-1:0] row_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            row_q <= identity_row();
         else if (we && (w_ev == EVT_W'(ev)))
            row_q[w_st*ENT_W +: ENT_W] <= {wexc, wnext};
      end
      assign rows[ev] = row_q;
   end

   assign rd_ok  = int'(rev) < NUM_EVENTS;
   assign rd_row = rd_ok ? rows[rev] : '0;
   assign rd_ent = rd_row[rst_sel*ENT_W +: ENT_W];
   assign rnext  = rd_ent[STATE_W-1:0];
   assign rexc   = rd_ent[ENT_W-1];
endmodule

// File: rtl/mon_event_mask.sv
module mon_event_mask #(
   parameter int NUM_EVENTS = 36
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [NUM_EVENTS-1:0]         wdata,
   input  logic [$clog2(NUM_EVENTS)-1:0] ev,
   output logic                          skip
);
   logic [NUM_EVENTS-1:0] mask_q;
   logic                  known;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= '0;
      else if (we)
         mask_q <= wdata;
   end

   assign known = int'(ev) < NUM_EVENTS;
   assign skip  = known ? mask_q[ev] : 1'b1;
endmodule

// File: rtl/mon_rule_lookup.sv
module mon_rule_lookup #(
   parameter int STATE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lk_valid,
   input  logic [STATE_W-1:0] lk_state,
   input  logic               skip,
   input  logic [STATE_W-1:0] ent_next,
   input  logic               ent_exc,
   output logic               rs_valid,
   output logic [STATE_W-1:0] rs_next,
   output logic               rs_exc,
   output logic               rs_changed,
   output logic               rs_bypass
);
   logic [STATE_W-1:0] nx;
   logic               ex;
   logic               ch;

   always_comb begin
      if (skip) begin
         nx = lk_state;
         ex = 1'b0;
      end else begin
         nx = ent_next;
         ex = ent_exc;
      end
      ch = !ex && (nx != lk_state);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !lk_valid) begin
         rs_valid   <= 1'b0;
         rs_next    <= '0;
         rs_exc     <= 1'b0;
         rs_changed <= 1'b0;
         rs_bypass  <= 1'b0;
      end else begin
         rs_valid   <= 1'b1;
         rs_next    <= nx;
         rs_exc     <= ex;
         rs_changed <= ch;
         rs_bypass  <= skip;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rs_valid);  // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_valid |-> (!rs_exc && !rs_changed && !rs_bypass && rs_next == '0));  // R2
   AST_BYPASS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && skip) |=> (rs_next == $past(lk_state) && !rs_exc && !rs_changed));  // R5
   AST_CHANGE_MEANS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (rs_changed == (!rs_exc && rs_next != $past(lk_state))));  // R7
endmodule

// File: rtl/mon_rule_table.sv
module mon_rule_table #(
   parameter int STATE_W    = 4,
   parameter int NUM_EVENTS = 36,
   localparam int EVT_W     = $clog2(NUM_EVENTS),
   localparam int IDX_W     = EVT_W + STATE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tbl_we,
   input  logic [IDX_W-1:0]      tbl_idx,
   input  logic [STATE_W-1:0]    tbl_next,
   input  logic                  tbl_exc,
   input  logic                  mask_we,
   input  logic [NUM_EVENTS-1:0] mask_wdata,
   input  logic                  lk_valid,
   input  logic [STATE_W-1:0]    lk_state,
   input  logic [EVT_W-1:0]      lk_event,
   output logic                  rs_valid,
   output logic [STATE_W-1:0]    rs_next,
   output logic                  rs_exc,
   output logic                  rs_changed,
   output logic                  rs_bypass
);
   import mon_rule_pkg::*;

   if (STATE_W < 1 || STATE_W > 8) begin : g_bad_state_w
      $error("mon_rule_table: STATE_W out of range");
   end
   if (NUM_EVENTS < EV_FIXED + 1) begin : g_bad_events
      $error("mon_rule_table: need the fixed events plus one user event");
   end
   if (NUM_EVENTS * (1 << STATE_W) > 4096) begin : g_too_big
      $error("mon_rule_table: table exceeds flop budget");
   end

   logic               skip;
   logic [STATE_W-1:0] ent_next;
   logic               ent_exc;

   mon_rule_store #(.STATE_W(STATE_W), .NUM_EVENTS(NUM_EVENTS)) i_store (
      .clk(clk), .rst_n(rst_n),
      .we(tbl_we), .widx(tbl_idx), .wnext(tbl_next), .wexc(tbl_exc),
      .rev(lk_event), .rst_sel(lk_state),
      .rnext(ent_next), .rexc(ent_exc)
   );

   mon_event_mask #(.NUM_EVENTS(NUM_EVENTS)) i_mask (
      .clk(clk), .rst_n(rst_n),
      .we(mask_we), .wdata(mask_wdata),
      .ev(lk_event), .skip(skip)
   );

   mon_rule_lookup #(.STATE_W(STATE_W)) i_lookup (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_state(lk_state),
      .skip(skip), .ent_next(ent_next), .ent_exc(ent_exc),
      .rs_valid(rs_valid), .rs_next(rs_next), .rs_exc(rs_exc),
      .rs_changed(rs_changed), .rs_bypass(rs_bypass)
   );

   AST_SKIP_TO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && skip) |=> rs_bypass);  // R5
   AST_UNKNOWN_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && int'(lk_event) >= NUM_EVENTS) |=> (rs_bypass && !rs_exc));  // R6
   AST_EXC_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rs_exc |-> (rs_valid && !rs_changed && !rs_bypass));  // R8
endmodule

// File: tb/test_mon_rule_table.sv
`timescale 1ns/100ps
module test_mon_rule_table;
   localparam int NE = 36;
   localparam int NS = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tbl_we = 1'b0;
   logic [9:0]    tbl_idx = '0;
   logic [3:0]    tbl_next = '0;
   logic          tbl_exc = 1'b0;
   logic          mask_we = 1'b0;
   logic [NE-1:0] mask_wdata = '0;
   logic          lk_valid = 1'b0;
   logic [3:0]    lk_state = '0;
   logic [5:0]    lk_event = '0;
   logic          rs_valid, rs_exc, rs_changed, rs_bypass;
   logic [3:0]    rs_next;

   mon_rule_table i_mon_rule_table (
      .clk(clk), .rst_n(rst_n),
      .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_next(tbl_next), .tbl_exc(tbl_exc),
      .mask_we(mask_we), .mask_wdata(mask_wdata),
      .lk_valid(lk_valid), .lk_state(lk_state), .lk_event(lk_event),
      .rs_valid(rs_valid), .rs_next(rs_next), .rs_exc(rs_exc),
      .rs_changed(rs_changed), .rs_bypass(rs_bypass)
   );

   always #2.5 clk = ~clk;

   bit [4:0]    shadow [NE*NS];
   bit [NE-1:0] shmask;
   logic [6:0]  exp_q [$];
   int          req_q [$];
   int          vectors = 0;
   int          bad = 0;
   bit          done = 1'b0;

   // expected {bypass, changed, exc, next}
   function automatic logic [6:0] model(logic [3:0] st, logic [5:0] ev);
      bit [4:0] e;
      if (int'(ev) >= NE) return {3'b100, st};
      if (shmask[ev]) return {3'b100, st};
      e = shadow[{ev, st}];
      return {1'b0, (!e[4] && e[3:0] != st), e[4], e[3:0]};
   endfunction

   task automatic cycle(input bit twe, input logic [9:0] tidx, input logic [3:0] tnx,
                        input bit tex, input bit mwe, input logic [NE-1:0] md,
                        input bit lv, input logic [3:0] st, input logic [5:0] ev,
                        input int rq);
      @(negedge clk);
      tbl_we = twe; tbl_idx = tidx; tbl_next = tnx; tbl_exc = tex;
      mask_we = mwe; mask_wdata = md;
      lk_valid = lv; lk_state = st; lk_event = ev;
      if (lv) begin
         exp_q.push_back(model(st, ev));
         req_q.push_back(rq);
      end
      if (twe && int'(tidx[9:4]) < NE) shadow[tidx] = {tex, tnx};
      if (mwe) shmask = md;
   endtask

   task automatic wr(input logic [5:0] ev, input logic [3:0] st, input logic [3:0] nx, input bit ex);
      cycle(1'b1, {ev, st}, nx, ex, 1'b0, '0, 1'b0, '0, '0, 0);
   endtask
   task automatic look(input logic [3:0] st, input logic [5:0] ev, input int rq);
      cycle(1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b1, st, ev, rq);
   endtask
   task automatic setmask(input logic [NE-1:0] m);
      cycle(1'b0, '0, '0, 1'b0, 1'b1, m, 1'b0, '0, '0, 0);
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cycle(1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0, '0, '0, 0);
   endtask

   // monitor: scoreboard compare one step after each rising edge
   always @(posedge clk) begin
      logic [6:0] got, want;
      int rq;
      #1;
      if (rst_n) begin
         got = {rs_bypass, rs_changed, rs_exc, rs_next};
         vectors++;
         if (rs_valid) begin
            if (exp_q.size() == 0) begin
               bad++;
               $display("FAIL R2: result without request, got %b expected none", got);
            end else begin
               want = exp_q.pop_front();
               rq = req_q.pop_front();
               if (got !== want) begin
                  bad++;
                  $display("FAIL R%0d: {byp,chg,exc,next} got %b expected %b", rq, got, want);
               end
            end
         end else if (exp_q.size() != 0) begin
            want = exp_q.pop_front();
            rq = req_q.pop_front();
            bad++;
            $display("FAIL R2: rs_valid 0, expected result %b (req R%0d)", want, rq);
         end else if (got !== 7'b0) begin
            bad++;
            $display("FAIL R2: idle outputs got %b expected 0000000", got);
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         bad++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NE*NS; i++) shadow[i] = {1'b0, 4'(i % NS)};
      shmask = '0;
      repeat (3) @(negedge clk);
      vectors++;
      if ({rs_valid, rs_bypass, rs_changed, rs_exc, rs_next} !== 8'b0) begin
         bad++;
         $display("FAIL R1: outputs in reset got %b expected 00000000",
                  {rs_valid, rs_bypass, rs_changed, rs_exc, rs_next});
      end
      rst_n = 1'b1;

      // R1: identity everywhere after reset, mask clear
      for (int s = 0; s < NS; s++) begin
         look(4'(s), 6'd0, 1);
         look(4'(s), 6'd3, 1);
         look(4'(s), 6'd4, 1);
         look(4'(s), 6'd35, 1);
      end

      // R3: heap-style rows
      wr(6'd4, 4'd1, 4'd2, 1'b0);   // user 0 on state 1 -> 2
      wr(6'd0, 4'd2, 4'd2, 1'b1);   // load on state 2 -> exception
      wr(6'd1, 4'd2, 4'd3, 1'b0);   // store on state 2 -> 3
      wr(6'd3, 4'd2, 4'd2, 1'b0);   // sub-word store keeps 2
      look(4'd1, 6'd4, 3);          // R3
      look(4'd2, 6'd0, 8);          // R8
      look(4'd2, 6'd1, 7);          // R7
      look(4'd2, 6'd3, 4);          // R4: own entry
      look(4'd2, 6'd2, 4);          // R4: sub-word load untouched
      look(4'd1, 6'd0, 4);          // R4: neighbour state untouched
      wr(6'd2, 4'd2, 4'd5, 1'b1);   // sub-word load gets its own rule
      look(4'd2, 6'd0, 4);          // R4: full-word load unchanged
      look(4'd2, 6'd2, 4);          // R4

      // R2: back-to-back distinct lookups
      look(4'd2, 6'd1, 2);
      look(4'd1, 6'd4, 2);
      look(4'd7, 6'd9, 2);
      look(4'd2, 6'd0, 2);
      idle(2);

      // R5: mask a load and a user event
      wr(6'd5, 4'd1, 4'd7, 1'b1);
      setmask(NE'(1) | (NE'(1) << 5));
      look(4'd2, 6'd0, 5);
      look(4'd1, 6'd5, 5);
      look(4'd2, 6'd1, 5);          // R5: unmasked store still uses table
      setmask('0);
      look(4'd2, 6'd0, 5);
      look(4'd1, 6'd5, 5);

      // R6: unknown event codes bypass; write there has no effect
      look(4'd3, 6'd36, 6);
      look(4'd3, 6'd63, 6);
      wr(6'd40, 4'd3, 4'd9, 1'b1);
      look(4'd3, 6'd40, 6);
      look(4'd3, 6'd35, 6);         // R6: last real code untouched by the write

      // R9: same-cycle table write and lookup see old entry
      cycle(1'b1, {6'd1, 4'd2}, 4'd9, 1'b0, 1'b0, '0, 1'b1, 4'd2, 6'd1, 9);
      look(4'd2, 6'd1, 9);
      // R9: same-cycle mask write uses old mask
      cycle(1'b0, '0, '0, 1'b0, 1'b1, NE'(1) << 1, 1'b1, 4'd2, 6'd1, 9);
      look(4'd2, 6'd1, 9);
      setmask('0);

      // R10: neutral entry
      wr(6'd4, 4'd1, 4'd1, 1'b0);
      look(4'd1, 6'd4, 10);

      // R8 / R7 sweep of the top event row
      for (int s = 0; s < NS; s++) wr(6'd35, 4'(s), ~4'(s), s[0]);
      for (int s = 0; s < NS; s++) look(4'(s), 6'd35, 8);

      idle(3);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
   end
endmodule